// File: doc/BRIEF.md
# Battery Charge Sequencer

This block is the control core of a simple battery charger. It steps through three modes: Idle, Charging and Protection. It watches three digital inputs, all of which may change at any time with respect to the clock. The first is a host charge request. The second is an over-voltage comparator flag. The third is a flag that reports the cell voltage as back under its safe level. The block drives a registered charge-enable and a 2-bit status code that the host can read.

Every input passes through a two-flop synchronizer before the state logic samples it. A charge request is not accepted until it has stayed high for an unbroken qualification window. The window is set in microseconds and converted to cycles from the clock frequency parameter. An over-voltage flag must also persist for its own window before it trips Protection, so a single spike does nothing. Once a charge starts, a timer limits it to a fixed number of cycles. After a protective disconnect, the sensor flags are ignored for a settle period before the block trusts the safe flag again.

Top module: `charge_sequencer`

## Requirements
- R1: While the synchronous active-low reset is held, and in the first cycle after it is released, status reads 0 (Idle) and charge_en is low.
- R2: status encodes the mode as Idle=0, Charging=1, Protection=2. charge_en is high exactly when status is 1. Both outputs are registered and change on the same edge.
- R3: Each input reaches the state logic through two flops, so the state logic first sees a changed input on the third rising edge after the change.
- R4: In Idle, Charging begins once the synchronized request has been high for REQ_QUAL_US x CLK_HZ/1e6 consecutive cycles. For a request that rises before rising edge k, status becomes 1 at edge k+REQ_CYC+1. A shorter pulse leaves the block in Idle.
- R5: If the request drops at any point in its window, the count clears, and the window starts again from the next rise.
- R6: Charging lasts exactly CHG_CYC cycles. The block then returns to Idle, unless a fault ends the charge first.
- R7: In Charging, an over-voltage flag that stays high for OVQ_CYC consecutive synchronized cycles moves the block to Protection and drops charge_en. A shorter burst has no effect.
- R8: For the first SETTLE_CYC cycles in Protection, the safe flag is ignored. The earliest possible return to Idle is SETTLE_CYC+1 cycles after entry.
- R9: Once the settle delay is over, a safe flag that rises before edge k returns the block to Idle at edge k+2.
- R10: An unused state code falls back to Idle, and status never reads 3.
- R11: The over-voltage flag has no effect in Idle. Protection is entered only from Charging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chg_req_a | input | 1 | Charge request from the host, asynchronous |
| ov_flag_a | input | 1 | Over-voltage comparator flag, asynchronous |
| safe_flag_a | input | 1 | Voltage below safe level, asynchronous |
| charge_en | output | 1 | Registered enable for the charge path |
| status | output | 2 | Mode code: 0 Idle, 1 Charging, 2 Protection |

## Verification
The bench checks request pulses one cycle shorter than the window, and a request that drops for one cycle in the middle of its window. A design with an off-by-one window, or one whose count holds instead of clearing, would start charging early. It compares the exact edges of every mode change against latencies computed from the two synchronizer stages. A missing or extra synchronizer stage would shift every transition by a cycle. It sends an over-voltage burst one cycle short of the window. It also holds the safe flag high through the whole settle period. A design that samples the flag at once would leave Protection right after entry. Finally, it asserts over-voltage while in Idle, where a design that does not check the mode would enter Protection.

// File: rtl/chg_pkg.sv
// Shared types for the charge sequencer.
// Assumes: the mode code doubles as the host status encoding.
package chg_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_CHG  = 2'd1,
        MODE_PROT = 2'd2
    } chg_mode_t;

endpackage

// File: rtl/chg_sync.sv
// Multi-stage flop synchronizer for a vector of independent asynchronous bits.
// Assumes: each bit is a slow level, so bits need no mutual coherence.
module chg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_rest
                // Let each later stage resolve metastability of the stage before.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/chg_run_cnt.sv
// Cycle counter with synchronous clear and count enable; clear wins.
// Assumes: the caller keeps the count below 2**W.
module chg_run_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Advance, clear or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end

endmodule

// File: rtl/chg_seq_fsm.sv
// Moore mode sequencer: Idle -> Charging -> (Idle | Protection -> Idle).
// Assumes: inputs are already synchronized, and every window parameter is at
// least 1 (SETTLE_CYC may be 0). A phase counter clears on every mode change.
module chg_seq_fsm
    import chg_pkg::*;
#(
    parameter int REQ_CYC    = 16,
    parameter int CHG_CYC    = 64,
    parameter int OVQ_CYC    = 4,
    parameter int SETTLE_CYC = 8,
    parameter int CW         = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       ov_s,
    input  logic       safe_s,
    output logic       charge_en,
    output logic [1:0] status
);

    localparam logic [CW-1:0] REQ_LAST = CW'(REQ_CYC - 1);
    localparam logic [CW-1:0] CHG_LAST = CW'(CHG_CYC - 1);
    localparam logic [CW-1:0] OVQ_LAST = CW'(OVQ_CYC - 1);
    localparam logic [CW-1:0] SETTLED  = CW'(SETTLE_CYC);

    chg_mode_t     mode_q, mode_d;
    logic [CW-1:0] phase_cnt, ov_cnt;
    logic          phase_clr, phase_inc, ov_clr, leaving;

    // Pick the next mode from the current mode, the counters and the inputs.
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_IDLE: if (req_s && phase_cnt == REQ_LAST) mode_d = MODE_CHG;
            MODE_CHG: begin
                if (ov_s && ov_cnt == OVQ_LAST)  mode_d = MODE_PROT;
                else if (phase_cnt == CHG_LAST)  mode_d = MODE_IDLE;
            end
            MODE_PROT: if (phase_cnt == SETTLED && safe_s) mode_d = MODE_IDLE;
            default: mode_d = MODE_IDLE;
        endcase
    end

    assign leaving = (mode_d != mode_q);

    // Drive the phase counter: request window, charge timer or settle delay.
    always_comb begin
        phase_clr = leaving;
        phase_inc = 1'b0;
        case (mode_q)
            MODE_IDLE: begin
                phase_clr = leaving || !req_s;
                phase_inc = req_s;
            end
            MODE_CHG:  phase_inc = 1'b1;
            MODE_PROT: phase_inc = (phase_cnt < SETTLED);
            default:   phase_clr = 1'b1;
        endcase
    end

    // The over-voltage window runs only while charging with the flag high.
    assign ov_clr = leaving || !(mode_q == MODE_CHG && ov_s);

    chg_run_cnt #(.W(CW)) u_phase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .inc   (phase_inc),
        .count (phase_cnt)
    );

    chg_run_cnt #(.W(CW)) u_ov_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ov_clr),
        .inc   (1'b1),
        .count (ov_cnt)
    );

    // Register the mode and the Moore outputs decoded from the next mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_IDLE;
            charge_en <= 1'b0;
            status    <= 2'd0;
        end else begin
            mode_q    <= mode_d;
            charge_en <= (mode_d == MODE_CHG);
            status    <= mode_d;
        end
    end

    // R4
    req_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CHG && $past(mode_q) == MODE_IDLE) |-> $past(req_s));

    // R6
    chg_timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CHG) |-> (phase_cnt < CW'(CHG_CYC)));

    // R7
    ov_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROT && $past(mode_q) == MODE_CHG) |-> $past(ov_s));

    // R8
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROT && phase_cnt < SETTLED) |=> (mode_q == MODE_PROT));

    // R11
    idle_no_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE) |=> (mode_q != MODE_PROT));

endmodule

// File: rtl/charge_sequencer.sv
// Top of the charge sequencer: synchronizes the three asynchronous inputs
// and feeds them to the mode sequencer. Windows are in clock cycles, except
// for the request window, which is set in microseconds at CLK_HZ.
// Assumes: CLK_HZ is a whole multiple of 1 MHz.
module charge_sequencer #(
    parameter int CLK_HZ      = 200_000_000,
    parameter int REQ_QUAL_US = 5000,
    parameter int CHG_CYC     = 2_000_000,
    parameter int OVQ_CYC     = 64,
    parameter int SETTLE_CYC  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_req_a,
    input  logic       ov_flag_a,
    input  logic       safe_flag_a,
    output logic       charge_en,
    output logic [1:0] status
);

    localparam int REQ_CYC  = (CLK_HZ / 1_000_000) * REQ_QUAL_US;
    localparam int MAX_AB   = (REQ_CYC > CHG_CYC) ? REQ_CYC : CHG_CYC;
    localparam int MAX_CD   = (OVQ_CYC > SETTLE_CYC + 1) ? OVQ_CYC : SETTLE_CYC + 1;
    localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W    = $clog2(MAX_CYC + 2);

    logic [2:0] flags_s;

    chg_sync #(.W(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({safe_flag_a, ov_flag_a, chg_req_a}),
        .sync_o  (flags_s)
    );

    chg_seq_fsm #(
        .REQ_CYC    (REQ_CYC),
        .CHG_CYC    (CHG_CYC),
        .OVQ_CYC    (OVQ_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CW         (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (flags_s[0]),
        .ov_s      (flags_s[1]),
        .safe_s    (flags_s[2]),
        .charge_en (charge_en),
        .status    (status)
    );

    // R2
    en_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        charge_en == (status == 2'd1));

    // R10
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);

endmodule

// File: tb/charge_sequencer_bench.sv
// Scoreboard bench: driver tasks queue expected mode changes with the cycle
// they must appear in; a negedge monitor pops and compares each change.
module charge_sequencer_bench;

    localparam int N    = 6;   // REQ_QUAL_US=6 at CLK_HZ=1 MHz
    localparam int CHG  = 40;
    localparam int OVQ  = 4;
    localparam int SETL = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, ov = 1'b0, safe = 1'b0;
    logic       charge_en;
    logic [1:0] status;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;
    logic [1:0] prev_st;

    logic [1:0] exp_st_q [$];
    int         exp_cyc_q [$];
    string      exp_tag_q [$];

    charge_sequencer #(
        .CLK_HZ      (1_000_000),
        .REQ_QUAL_US (N),
        .CHG_CYC     (CHG),
        .OVQ_CYC     (OVQ),
        .SETTLE_CYC  (SETL)
    ) u_charge_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .chg_req_a   (req),
        .ov_flag_a   (ov),
        .safe_flag_a (safe),
        .charge_en   (charge_en),
        .status      (status)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input logic [1:0] st, input int at, input string tag);
        exp_st_q.push_back(st);
        exp_cyc_q.push_back(at);
        exp_tag_q.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_status(input logic [1:0] st);
        while (status !== st) @(negedge clk);
    endtask

    // Monitor: every change of status must match the head of the queue.
    always @(negedge clk) begin
        if (mon_on && status !== prev_st) begin
            if (exp_st_q.size() == 0) begin
                check(1'b0, "R4/R11 unexpected mode change", int'(status), int'(prev_st));
            end else begin
                logic [1:0] es;
                int         ec;
                string      et;
                es = exp_st_q.pop_front();
                ec = exp_cyc_q.pop_front();
                et = exp_tag_q.pop_front();
                check(status === es, {et, " status"}, int'(status), int'(es));
                check(cyc == ec, {et, " cycle"}, cyc, ec);
                check(charge_en === (es == 2'd1), {et, " R2 charge_en"}, int'(charge_en), int'(es == 2'd1));
            end
            prev_st = status;
        end
    end

    initial begin : watchdog
        #(5 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        int t, c, e;
        idle_for(4);
        check(status === 2'd0, "R1 status in reset", int'(status), 0);
        check(charge_en === 1'b0, "R1 charge_en in reset", int'(charge_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(status === 2'd0 && charge_en === 1'b0, "R1 after release", int'(status), 0);
        prev_st = status;
        mon_on = 1'b1;

        // R4: a pulse one cycle short of the window is ignored.
        req = 1'b1;
        idle_for(N - 1);
        req = 1'b0;
        idle_for(20);
        check(status === 2'd0, "R4 short request ignored", int'(status), 0);

        // R5: a one-cycle drop restarts the window. R3: two-stage latency.
        req = 1'b1;
        idle_for(N - 2);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        t = cyc;
        c = t + N + 2;
        expect_at(2'd1, c, "R5 R3 restarted window");
        // R6: charge ends after exactly CHG cycles.
        expect_at(2'd0, c + CHG, "R6 charge duration");
        wait_status(2'd1);
        req = 1'b0;
        wait_status(2'd0);
        idle_for(5);

        // R11: over-voltage in Idle has no effect.
        ov = 1'b1;
        idle_for(20);
        check(status === 2'd0, "R11 ov ignored in idle", int'(status), 0);
        ov = 1'b0;
        idle_for(5);

        // R7: short burst ignored, then a held fault trips Protection.
        req = 1'b1;
        t = cyc;
        c = t + N + 2;
        expect_at(2'd1, c, "R4 request window");
        wait_status(2'd1);
        req = 1'b0;
        idle_for(2);
        ov = 1'b1;
        idle_for(OVQ - 1);
        ov = 1'b0;
        idle_for(4);
        check(status === 2'd1, "R7 short ov burst ignored", int'(status), 1);
        ov = 1'b1;
        t = cyc;
        e = t + OVQ + 2;
        expect_at(2'd2, e, "R7 fault qualified");
        wait_status(2'd2);
        ov = 1'b0;
        // R9: release after the settle delay with a late safe flag.
        while (cyc < e + SETL + 4) @(negedge clk);
        check(status === 2'd2, "R8 holds until safe", int'(status), 2);
        safe = 1'b1;
        t = cyc;
        expect_at(2'd0, t + 3, "R9 late safe flag");
        wait_status(2'd0);
        safe = 1'b0;
        idle_for(5);

        // R8: safe held high through the settle period is ignored until it ends.
        safe = 1'b1;
        req = 1'b1;
        t = cyc;
        c = t + N + 2;
        expect_at(2'd1, c, "R4 second charge");
        wait_status(2'd1);
        req = 1'b0;
        idle_for(5);
        ov = 1'b1;
        t = cyc;
        e = t + OVQ + 2;
        expect_at(2'd2, e, "R7 second fault");
        expect_at(2'd0, e + SETL + 1, "R8 settle delay");
        wait_status(2'd2);
        ov = 1'b0;
        wait_status(2'd0);
        safe = 1'b0;
        idle_for(10);

        check(exp_st_q.size() == 0, "R2 pending expectations", exp_st_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule